// File: doc/BRIEF.md
# Frequency Meter Gate Sequencer

This block sequences a single measurement of a frequency meter. It runs on the gate timebase clock. A launch request moves it out of its waiting state and opens the counting gate for exactly one timebase period. It then closes the gate and waits until the launch request has been withdrawn. Only after that can another measurement begin. An external pulse counter counts only while the gate-enable output is high.

A second output tells the counter and display logic whether the count may be cleared. It is high while the sequencer waits. It drops when the gate opens and stays low until the sequencer is back in its waiting state, so the finished count stays on the display for as long as the launch request is held.

The three states are waiting, gate open and done. A parameter picks either a binary or a one-hot state register; the behaviour seen at the ports is the same for both. Both outputs come straight from flip-flops.

Top module: `fm_gate_ctrl`

## Requirements
- R1: An asynchronous active-high reset puts the sequencer in the waiting state at once, with gate_en_o = 0 and clear_allow_o = 1, and holds it there while reset is high.
- R2: In the waiting state, a clock edge with launch_i = 0 keeps the sequencer waiting, with gate_en_o = 0 and clear_allow_o = 1.
- R3: In the waiting state, a clock edge with launch_i = 1 enters the gate-open state, where gate_en_o = 1 and clear_allow_o = 0.
- R4: The gate-open state lasts exactly one clock period. The next edge always enters the done state, whatever launch_i is, so gate_en_o is high for exactly one cycle.
- R5: In the done state, each edge with launch_i = 1 keeps the sequencer in the done state, with gate_en_o = 0 and clear_allow_o held at 0.
- R6: In the done state, an edge with launch_i = 0 returns the sequencer to the waiting state, with gate_en_o = 0 and clear_allow_o = 1.
- R7: After a gate interval, gate_en_o does not rise again until launch_i has been sampled low at a clock edge. A launch held high through a cycle therefore produces exactly one gate interval.
- R8: gate_en_o and clear_allow_o are never both 1. Both outputs change only at a rising clock edge or at reset.
- R9: The binary state encoding (ONE_HOT = 0) and the one-hot state encoding (ONE_HOT = 1) give identical port behaviour. The state register never holds an illegal code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Gate timebase clock, rising edge active |
| rst_i | input | 1 | Asynchronous reset, active high |
| launch_i | input | 1 | Measurement launch request |
| gate_en_o | output | 1 | Enables the external pulse counter while high |
| clear_allow_o | output | 1 | High when the counter and display may be cleared |

## Verification
The assertions check every cycle that each transition from the waiting and done states goes to the right state with the right outputs. They also check that the gate is always one cycle long, that the two outputs are never high together, and that the state register holds only legal codes. A small flag in the assertion logic checks that the gate cannot reopen without a low launch sample in between. The bench's scenarios are needed for the things a property cannot show:
- a reset that arrives between clock edges in the middle of a gate;
- a launch held high across a whole measurement, with its gate pulses counted;
- the two encodings, run side by side and compared with a behavioural model.

// File: rtl/fm_gate_pkg.sv
package fm_gate_pkg;

   // Logical states of the measurement sequencer
   typedef enum logic [1:0] {
      ST_IDLE      = 2'd0,
      ST_GATE_OPEN = 2'd1,
      ST_DONE      = 2'd2
   } fm_state_e;

   localparam int unsigned NUM_STATES = 3;
   localparam int unsigned BIN_W      = $clog2(NUM_STATES);

   // Output values taken in the waiting state (also the reset values)
   localparam logic IDLE_GATE  = 1'b0;
   localparam logic IDLE_CLEAR = 1'b1;

endpackage

// File: rtl/fm_state_reg.sv
module fm_state_reg
   import fm_gate_pkg::*;
#(
   parameter bit ONE_HOT = 1'b0
) (
   input  logic      clk_i,
   input  logic      rst_i,
   input  fm_state_e nxt_state_i,
   input  logic      nxt_gate_i,
   input  logic      nxt_clear_i,
   output fm_state_e cur_state_o,
   output logic      gate_q_o,
   output logic      clear_q_o
);

   // Output flip-flops: loaded together with the state
   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) begin
         gate_q_o  <= IDLE_GATE;
         clear_q_o <= IDLE_CLEAR;
      end else begin
         gate_q_o  <= nxt_gate_i;
         clear_q_o <= nxt_clear_i;
      end
   end

   generate
      if (ONE_HOT) begin : g_onehot
         localparam int unsigned OH_W = NUM_STATES;
         logic [OH_W-1:0] oh_q;
         logic [OH_W-1:0] oh_d;

         always_comb begin
            oh_d = '0;
            oh_d[nxt_state_i] = 1'b1;
         end

         always_ff @(posedge clk_i or posedge rst_i) begin
            if (rst_i) oh_q <= OH_W'(1) << ST_IDLE;
            else       oh_q <= oh_d;
         end

         always_comb begin
            cur_state_o = ST_IDLE;
            for (int i = 0; i < int'(OH_W); i++) begin
               if (oh_q[i]) cur_state_o = fm_state_e'(i);
            end
         end

         // R9: exactly one state bit set at all times
         assert_onehot_legal_R9: assert property (@(posedge clk_i) disable iff (rst_i)
            $countones(oh_q) == 1)
            else $error("one-hot state register holds %b", oh_q);
      end else begin : g_binary
         logic [BIN_W-1:0] bin_q;

         always_ff @(posedge clk_i or posedge rst_i) begin
            if (rst_i) bin_q <= BIN_W'(ST_IDLE);
            else       bin_q <= BIN_W'(nxt_state_i);
         end

         assign cur_state_o = fm_state_e'(bin_q);

         // R9: binary code stays within the defined states
         assert_binary_legal_R9: assert property (@(posedge clk_i) disable iff (rst_i)
            int'(bin_q) < int'(NUM_STATES))
            else $error("binary state register holds %0d", bin_q);
      end
   endgenerate

endmodule

// File: rtl/fm_next_logic.sv
module fm_next_logic
   import fm_gate_pkg::*;
(
   input  fm_state_e cur_state_i,
   input  logic      launch_i,
   input  logic      clear_q_i,
   output fm_state_e nxt_state_o,
   output logic      nxt_gate_o,
   output logic      nxt_clear_o
);

   always_comb begin
      nxt_state_o = cur_state_i;
      unique case (cur_state_i)
         ST_IDLE:      if (launch_i)  nxt_state_o = ST_GATE_OPEN;
         ST_GATE_OPEN:                nxt_state_o = ST_DONE;
         ST_DONE:      if (!launch_i) nxt_state_o = ST_IDLE;
         default:                     nxt_state_o = ST_IDLE;
      endcase
   end

   // Moore outputs of the state being entered; the done state leaves
   // the clear permission untouched, so it keeps the gate-open value.
   always_comb begin
      nxt_gate_o  = IDLE_GATE;
      nxt_clear_o = clear_q_i;
      unique case (nxt_state_o)
         ST_IDLE: begin
            nxt_gate_o  = IDLE_GATE;
            nxt_clear_o = IDLE_CLEAR;
         end
         ST_GATE_OPEN: begin
            nxt_gate_o  = 1'b1;
            nxt_clear_o = 1'b0;
         end
         ST_DONE: begin
            nxt_gate_o  = 1'b0;
            nxt_clear_o = clear_q_i;
         end
         default: begin
            nxt_gate_o  = IDLE_GATE;
            nxt_clear_o = IDLE_CLEAR;
         end
      endcase
   end

endmodule

// File: rtl/fm_gate_ctrl.sv
module fm_gate_ctrl
   import fm_gate_pkg::*;
#(
   parameter int ONE_HOT = 0
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic launch_i,
   output logic gate_en_o,
   output logic clear_allow_o
);

   initial begin
      assert (ONE_HOT == 0 || ONE_HOT == 1)
         else $error("ONE_HOT must be 0 or 1, got %0d", ONE_HOT);
   end

   fm_state_e cur_state;
   fm_state_e nxt_state;
   logic      nxt_gate;
   logic      nxt_clear;

   fm_next_logic u_next (
      .cur_state_i (cur_state),
      .launch_i    (launch_i),
      .clear_q_i   (clear_allow_o),
      .nxt_state_o (nxt_state),
      .nxt_gate_o  (nxt_gate),
      .nxt_clear_o (nxt_clear)
   );

   fm_state_reg #(.ONE_HOT(ONE_HOT != 0)) u_state (
      .clk_i       (clk_i),
      .rst_i       (rst_i),
      .nxt_state_i (nxt_state),
      .nxt_gate_i  (nxt_gate),
      .nxt_clear_i (nxt_clear),
      .cur_state_o (cur_state),
      .gate_q_o    (gate_en_o),
      .clear_q_o   (clear_allow_o)
   );

   // R1: while reset is high, outputs sit at waiting values
   always @(negedge clk_i) begin
      if (rst_i) begin
         assert_reset_outputs_R1: assert (!gate_en_o && clear_allow_o && cur_state == ST_IDLE)
            else $error("outputs not at reset values during reset");
      end
   end

   assert_idle_stay_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      (cur_state == ST_IDLE && !launch_i) |=> (cur_state == ST_IDLE && !gate_en_o && clear_allow_o))
      else $error("waiting state left without launch");

   assert_idle_launch_R3: assert property (@(posedge clk_i) disable iff (rst_i)
      (cur_state == ST_IDLE && launch_i) |=> (cur_state == ST_GATE_OPEN && gate_en_o && !clear_allow_o))
      else $error("launch did not open the gate");

   assert_gate_one_cycle_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      gate_en_o |=> (!gate_en_o && cur_state == ST_DONE))
      else $error("gate open longer than one cycle");

   assert_done_hold_R5: assert property (@(posedge clk_i) disable iff (rst_i)
      (cur_state == ST_DONE && launch_i) |=> (cur_state == ST_DONE && !gate_en_o && !clear_allow_o))
      else $error("done state not held while launch high");

   assert_done_release_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      (cur_state == ST_DONE && !launch_i) |=> (cur_state == ST_IDLE && clear_allow_o))
      else $error("done state did not return to waiting");

   assert_outputs_exclusive_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      !(gate_en_o && clear_allow_o))
      else $error("gate and clear permission high together");

   // R7 checker: remembers whether launch was sampled low since the last gate
   logic low_seen_q;
   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i)           low_seen_q <= 1'b1;
      else if (!launch_i)  low_seen_q <= 1'b1;
      else if (nxt_gate)   low_seen_q <= 1'b0;
   end

   assert_rearm_needs_low_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      (!gate_en_o && nxt_gate) |-> low_seen_q)
      else $error("gate reopened without launch going low");

endmodule

// File: tb/fm_gate_ctrl_tb.sv
`timescale 1ns/1ps
module fm_gate_ctrl_tb;

   logic clk = 1'b0;
   logic rst = 1'b0;
   logic launch = 1'b0;
   logic gate_b, clear_b, gate_h, clear_h;

   int checks = 0;
   int failures = 0;
   bit done_flag = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   fm_gate_ctrl #(.ONE_HOT(0)) u_dut (
      .clk_i(clk), .rst_i(rst), .launch_i(launch),
      .gate_en_o(gate_b), .clear_allow_o(clear_b));

   fm_gate_ctrl #(.ONE_HOT(1)) u_dut_oh (
      .clk_i(clk), .rst_i(rst), .launch_i(launch),
      .gate_en_o(gate_h), .clear_allow_o(clear_h));

   // Behavioural reference: 0 waiting, 1 gate open, 2 done
   int    m_st   = 0;
   bit    m_gate = 1'b0;
   bit    m_clr  = 1'b1;
   string m_tag  = "R1";

   always @(posedge clk or posedge rst) begin
      if (rst) begin
         m_st = 0; m_gate = 1'b0; m_clr = 1'b1; m_tag = "R1";
      end else begin
         case (m_st)
            0: if (launch) begin
                  m_st = 1; m_gate = 1'b1; m_clr = 1'b0; m_tag = "R3";
               end else m_tag = "R2";
            1: begin m_st = 2; m_gate = 1'b0; m_tag = "R4"; end
            default: if (launch) m_tag = "R5";
               else begin m_st = 0; m_clr = 1'b1; m_tag = "R6"; end
         endcase
      end
   end

   task automatic check(string tag, logic act, logic exp, string what);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
      end
   endtask

   // Per-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (!done_flag) begin
         check(m_tag, gate_b,  m_gate, "gate_en (binary)");
         check(m_tag, clear_b, m_clr,  "clear_allow (binary)");
         check("R9", gate_h,  gate_b,  "gate_en one-hot vs binary");
         check("R9", clear_h, clear_b, "clear_allow one-hot vs binary");
         check("R8", gate_b & clear_b, 1'b0, "outputs both high");
      end
   end

   task automatic cycles(int n);
      repeat (n) @(negedge clk);
   endtask

   int pulses;
   logic prev_gate;

   initial begin
      #1 rst = 1'b1;
      #0.5;
      check("R1", gate_b, 1'b0, "gate_en right after reset edge");
      check("R1", clear_b, 1'b1, "clear_allow right after reset edge");
      cycles(3);
      rst = 1'b0;

      // R2: stay waiting with launch low
      cycles(4);
      check("R2", gate_b, 1'b0, "gate_en while waiting");

      // R3/R4/R6: single-cycle launch
      launch = 1'b1;
      cycles(1);
      launch = 1'b0;
      check("R3", gate_b, 1'b1, "gate open after launch");
      cycles(1);
      check("R4", gate_b, 1'b0, "gate closed after one cycle");
      check("R4", clear_b, 1'b0, "clear held low in done");
      cycles(1);
      check("R6", clear_b, 1'b1, "clear allowed after return");

      // R7/R5: launch held high across a whole measurement
      launch = 1'b1;
      pulses = 0;
      prev_gate = gate_b;
      for (int i = 0; i < 10; i++) begin
         cycles(1);
         if (gate_b && !prev_gate) pulses++;
         prev_gate = gate_b;
      end
      checks++;
      if (pulses != 1) begin
         failures++;
         $display("FAIL R7 gate pulses with launch held actual=%0d expected=1", pulses);
      end
      check("R5", clear_b, 1'b0, "clear held low while launch held");
      launch = 1'b0;
      cycles(1);
      check("R6", clear_b, 1'b1, "return to waiting on launch low");
      launch = 1'b1;
      cycles(1);
      check("R7", gate_b, 1'b1, "new gate after launch seen low");

      // R4: launch toggling does not stretch the gate
      launch = 1'b0;
      cycles(1);
      check("R4", gate_b, 1'b0, "gate one cycle with launch low");
      launch = 1'b1;
      cycles(2);
      launch = 1'b0;
      cycles(2);

      // R1: asynchronous reset in the middle of a gate
      launch = 1'b1;
      @(posedge clk);
      #1 rst = 1'b1;
      #0.5;
      check("R1", gate_b, 1'b0, "gate dropped by async reset");
      check("R1", clear_b, 1'b1, "clear restored by async reset");
      check("R1", gate_h, 1'b0, "one-hot gate dropped by async reset");
      cycles(2);
      check("R1", gate_b, 1'b0, "gate held low during reset with launch high");
      rst = 1'b0;
      cycles(1);
      check("R3", gate_b, 1'b1, "launch high after reset opens gate");
      launch = 1'b0;
      cycles(3);

      done_flag = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #20000;
      if (!done_flag) begin
         done_flag = 1'b1;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule